// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block sits on the byte-wide register port of an 8259-style programmable interrupt controller. A one-bit address (`wr_a0`) splits the port into two locations. The decoder sorts each accepted write into one of three groups: the initialization sequence (four words, two of them optional), a mask load, or one of the two operation commands. It turns each write into stored control fields and one-cycle command strobes for a separate priority resolver. That resolver, which is outside this block, owns the request and in-service registers and the priority arithmetic that needs them.

Writes arrive on a valid/ready stream. `wr_ready` is tied high, so the block never applies back-pressure. A write is taken in every cycle that `wr_valid` is high, back-to-back writes included. Each field and strobe changes at the clock edge that accepts the write. Strobes stay high for exactly that one following cycle. Reads are plain control pins: `rd_data` is combinational from `rd_a0`. `rd_en` matters only because a read of address 0 ends a pending poll.

Top module: `pic_cmd_decoder`

## Requirements
- R1: An accepted write at address 0 with bit 4 set starts initialization. On the next cycle `init_start` and `base_load` pulse with `base_val` = 0. The mask, rotate-on-auto-EOI, auto-EOI, nested mode, special mask, read select and poll all return to 0. `single_mode` takes data bit 1, the fourth-word flag takes data bit 0, and `init_busy` goes high, waiting for the second word.
- R2: When that start write also has bit 3 set (level-triggered mode, which is not supported), `level_err` pulses for one cycle. It stays low for every other write.
- R3: The address-1 write that follows the start write loads `vec_base` with the data ANDed with 0xF8.
- R4: After the second word, the next state depends on the mode. In cascade mode (`single_mode` = 0) the block waits for a third word. After that word it waits for a fourth word if the flag is set, and otherwise finishes. In single mode it goes straight to the fourth word if the flag is set, and otherwise finishes. The third word changes no field. The fourth word always finishes. `init_busy` is high from the start write until the sequence finishes. Address-1 writes during the sequence never touch the mask.
- R5: The fourth word sets `nested_mode` from data bit 4 and `auto_eoi` from data bit 1.
- R6: An accepted address-1 write while `init_busy` is low loads `imr` with the data.
- R7: An address-0 write with bit 4 clear and bit 3 set is a status command. Bit 2 set raises `poll_mode`. Bit 1 set loads `read_isr` from bit 0, and bit 1 clear leaves it unchanged. Bit 6 set loads `special_mask` from bit 5, and bit 6 clear leaves it unchanged.
- R8: An address-0 write with bits 4 and 3 clear is an end/rotate command with code = data[7:5]. Code 0 clears `rot_on_aeoi` and code 4 sets it.
- R9: Code 1 pulses `eoi_ns`. Code 5 pulses `eoi_ns` and `eoi_rotate` together. Code 3 pulses `eoi_sp` and sets `eoi_level` = data[2:0]. Code 7 does the same as code 3 and also pulses `base_load` with `base_val` = (data[2:0]+1) mod 8. `eoi_level` holds its value between specific commands.
- R10: Code 6 pulses `base_load` alone with `base_val` = (data[2:0]+1) mod 8. Code 2 changes nothing.
- R11: `rd_data` shows `imr` when `rd_a0` = 1. When `rd_a0` = 0 it shows `isr_in` if `read_isr` is set and `irr_in` otherwise. A read with `rd_en` high at address 0 clears `poll_mode`, unless the same cycle accepts a write that sets it.
- R12: `wr_ready` is always 1, and a write is accepted in every cycle that `wr_valid` is high.
- R13: After reset every field and strobe is 0, `init_busy` is low and reads of address 0 show `irr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready, always 1 |
| wr_a0 | input | 1 | Write address bit |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe (clears poll on address 0) |
| rd_a0 | input | 1 | Read address bit |
| rd_data | output | 8 | Read data |
| irr_in | input | 8 | Request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| init_busy | output | 1 | Initialization sequence in progress |
| single_mode | output | 1 | Single (non-cascaded) controller |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_on_aeoi | output | 1 | Rotate on automatic end of interrupt |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Address-0 read selects in-service register |
| poll_mode | output | 1 | Poll command pending |
| init_start | output | 1 | Pulse: initialization began (clear resolver state) |
| level_err | output | 1 | Pulse: unsupported level mode requested |
| eoi_ns | output | 1 | Pulse: non-specific end of interrupt |
| eoi_sp | output | 1 | Pulse: specific end of interrupt |
| eoi_rotate | output | 1 | Pulse: rotate with the non-specific end |
| eoi_level | output | 3 | Level for specific end of interrupt |
| base_load | output | 1 | Pulse: load new lowest-priority base |
| base_val | output | 3 | New priority base |

## Verification
On every cycle the bound properties check the write-to-field relations one edge apart:
- the start word clearing the state;
- the level-mode flag following bit 3;
- the vector base masking;
- mask loads happening only outside initialization, with the mask frozen inside it;
- the fourth word ending the sequence;
- the end-of-interrupt strobes never firing together.

Which path the sequence takes through the optional words, the eight end/rotate codes, the keep-unchanged rules of the status command, and the read multiplexer over live inputs can only be shown by the bench's scenarios. The bench compares all of these against its behavioural model on every clock, under both directed and random traffic.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_ICW2  = 2'd1,
    ST_ICW3  = 2'd2,
    ST_ICW4  = 2'd3
  } init_st_e;

  // End/rotate command code, taken from data[7:5]
  typedef enum logic [2:0] {
    OP_ROT_CLR    = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } ocw2_op_e;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_START,
    WK_INIT_DATA,
    WK_MASK,
    WK_ENDROT,
    WK_STATUS
  } wr_kind_e;
endpackage

// File: rtl/pic_cmd_classify.sv
module pic_cmd_classify
  import pic_cmd_pkg::*;
(
  input  logic     fire,
  input  logic     a0,
  input  logic     bit4,
  input  logic     bit3,
  input  logic     busy,
  output wr_kind_e kind
);
  always_comb begin
    if (!fire)     kind = WK_NONE;
    else if (a0)   kind = busy ? WK_INIT_DATA : WK_MASK;
    else if (bit4) kind = WK_START;
    else if (bit3) kind = WK_STATUS;
    else           kind = WK_ENDROT;
  end
endmodule

// File: rtl/pic_cmd_init_seq.sv
module pic_cmd_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_kind_e      kind,
  input  logic [DW-1:0] d,
  output init_st_e      st,
  output logic          busy,
  output logic [DW-1:0] vec_base,
  output logic          single_mode,
  output logic          auto_eoi,
  output logic          nested_mode,
  output logic          init_start,
  output logic          level_err
);
  localparam logic [DW-1:0] LVL_MASK = DW'((1 << LVL_W) - 1);

  logic need4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_READY;
      need4       <= 1'b0;
      single_mode <= 1'b0;
      vec_base    <= '0;
      auto_eoi    <= 1'b0;
      nested_mode <= 1'b0;
      init_start  <= 1'b0;
      level_err   <= 1'b0;
    end else begin
      init_start <= 1'b0;
      level_err  <= 1'b0;
      if (kind == WK_START) begin
        st          <= ST_ICW2;
        single_mode <= d[1];
        need4       <= d[0];
        auto_eoi    <= 1'b0;
        nested_mode <= 1'b0;
        init_start  <= 1'b1;
        level_err   <= d[3];
      end else if (kind == WK_INIT_DATA) begin
        unique case (st)
          ST_ICW2: begin
            vec_base <= d & ~LVL_MASK;
            if (!single_mode) st <= ST_ICW3;
            else              st <= need4 ? ST_ICW4 : ST_READY;
          end
          ST_ICW3: st <= need4 ? ST_ICW4 : ST_READY;
          ST_ICW4: begin
            nested_mode <= d[4];
            auto_eoi    <= d[1];
            st          <= ST_READY;
          end
          default: st <= ST_READY;
        endcase
      end
    end
  end

  assign busy = (st != ST_READY);
endmodule

// File: rtl/pic_cmd_ocw.sv
module pic_cmd_ocw
  import pic_cmd_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_kind_e         kind,
  input  logic [DW-1:0]    d,
  input  logic             poll_ack,
  output logic [DW-1:0]    imr,
  output logic             rot_on_aeoi,
  output logic             special_mask,
  output logic             read_isr,
  output logic             poll_mode,
  output logic             eoi_ns,
  output logic             eoi_sp,
  output logic             eoi_rotate,
  output logic [LVL_W-1:0] eoi_level,
  output logic             base_load,
  output logic [LVL_W-1:0] base_val
);
  ocw2_op_e          op;
  logic [LVL_W-1:0]  lvl;
  logic [LVL_W-1:0]  lvl_next;

  assign op       = ocw2_op_e'(d[7:5]);
  assign lvl      = d[LVL_W-1:0];
  assign lvl_next = lvl + LVL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr          <= '0;
      rot_on_aeoi  <= 1'b0;
      special_mask <= 1'b0;
      read_isr     <= 1'b0;
      poll_mode    <= 1'b0;
      eoi_ns       <= 1'b0;
      eoi_sp       <= 1'b0;
      eoi_rotate   <= 1'b0;
      eoi_level    <= '0;
      base_load    <= 1'b0;
      base_val     <= '0;
    end else begin
      eoi_ns     <= 1'b0;
      eoi_sp     <= 1'b0;
      eoi_rotate <= 1'b0;
      base_load  <= 1'b0;
      if (poll_ack) poll_mode <= 1'b0;
      unique case (kind)
        WK_START: begin
          imr          <= '0;
          rot_on_aeoi  <= 1'b0;
          special_mask <= 1'b0;
          read_isr     <= 1'b0;
          poll_mode    <= 1'b0;
          base_load    <= 1'b1;
          base_val     <= '0;
        end
        WK_MASK: imr <= d;
        WK_STATUS: begin
          if (d[2]) poll_mode    <= 1'b1;
          if (d[1]) read_isr     <= d[0];
          if (d[6]) special_mask <= d[5];
        end
        WK_ENDROT: begin
          unique case (op)
            OP_ROT_CLR: rot_on_aeoi <= 1'b0;
            OP_ROT_SET: rot_on_aeoi <= 1'b1;
            OP_EOI_NS:  eoi_ns      <= 1'b1;
            OP_EOI_NS_ROT: begin
              eoi_ns     <= 1'b1;
              eoi_rotate <= 1'b1;
            end
            OP_EOI_SP: begin
              eoi_sp    <= 1'b1;
              eoi_level <= lvl;
            end
            OP_EOI_SP_ROT: begin
              eoi_sp    <= 1'b1;
              eoi_level <= lvl;
              base_load <= 1'b1;
              base_val  <= lvl_next;
            end
            OP_SET_PRIO: begin
              base_load <= 1'b1;
              base_val  <= lvl_next;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic       wr_a0,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_a0,
  output logic [7:0] rd_data,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  output logic [7:0] imr,
  output logic [7:0] vec_base,
  output logic       init_busy,
  output logic       single_mode,
  output logic       auto_eoi,
  output logic       rot_on_aeoi,
  output logic       nested_mode,
  output logic       special_mask,
  output logic       read_isr,
  output logic       poll_mode,
  output logic       init_start,
  output logic       level_err,
  output logic       eoi_ns,
  output logic       eoi_sp,
  output logic       eoi_rotate,
  output logic [2:0] eoi_level,
  output logic       base_load,
  output logic [2:0] base_val
);
  // Command bit positions assume one data bit per request line (8).
  localparam int DW    = N_LINES;
  localparam int LVL_W = $clog2(N_LINES);

  wr_kind_e kind;
  init_st_e seq_st;
  logic     fire;
  logic     poll_ack;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid & wr_ready;
  assign poll_ack = rd_en & ~rd_a0;

  pic_cmd_classify u_cls (
    .fire (fire),
    .a0   (wr_a0),
    .bit4 (wr_data[4]),
    .bit3 (wr_data[3]),
    .busy (init_busy),
    .kind (kind)
  );

  pic_cmd_init_seq #(.DW(DW), .LVL_W(LVL_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .d           (wr_data),
    .st          (seq_st),
    .busy        (init_busy),
    .vec_base    (vec_base),
    .single_mode (single_mode),
    .auto_eoi    (auto_eoi),
    .nested_mode (nested_mode),
    .init_start  (init_start),
    .level_err   (level_err)
  );

  pic_cmd_ocw #(.DW(DW), .LVL_W(LVL_W)) u_ocw (
    .clk          (clk),
    .rst_n        (rst_n),
    .kind         (kind),
    .d            (wr_data),
    .poll_ack     (poll_ack),
    .imr          (imr),
    .rot_on_aeoi  (rot_on_aeoi),
    .special_mask (special_mask),
    .read_isr     (read_isr),
    .poll_mode    (poll_mode),
    .eoi_ns       (eoi_ns),
    .eoi_sp       (eoi_sp),
    .eoi_rotate   (eoi_rotate),
    .eoi_level    (eoi_level),
    .base_load    (base_load),
    .base_val     (base_val)
  );

  always_comb begin
    if (rd_a0)         rd_data = imr;
    else if (read_isr) rd_data = isr_in;
    else               rd_data = irr_in;
  end
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk
  import pic_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       fire,
  input logic       wr_a0,
  input logic [7:0] wr_data,
  input init_st_e   seq_st,
  input logic       init_busy,
  input logic       init_start,
  input logic       base_load,
  input logic [2:0] base_val,
  input logic [7:0] imr,
  input logic       level_err,
  input logic [7:0] vec_base,
  input logic       eoi_ns,
  input logic       eoi_sp,
  input logic       eoi_rotate
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wr_a0 && wr_data[4] |=> init_start && base_load && base_val == 3'd0
                                     && imr == 8'h00 && init_busy);

  p_level_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !wr_a0 && wr_data[4] |=> level_err == $past(wr_data[3]));

  p_vec_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wr_a0 && seq_st == ST_ICW2 |=> vec_base == ($past(wr_data) & 8'hF8));

  p_mask_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wr_a0 && init_busy |=> $stable(imr));

  p_fourth_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wr_a0 && seq_st == ST_ICW4 |=> !init_busy);

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && wr_a0 && !init_busy |=> imr == $past(wr_data));

  p_eoi_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoi_ns, eoi_sp}));

  p_rot_with_ns_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_rotate |-> eoi_ns);
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk u_chk (.*);

// File: tb/sim_pic_cmd_decoder.sv
module sim_pic_cmd_decoder;
  localparam time CYC = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_a0 = 1'b0, rd_en = 1'b0, rd_a0 = 1'b0;
  logic [7:0] wr_data = '0, irr_in = '0, isr_in = '0;
  logic wr_ready, init_busy, single_mode, auto_eoi, rot_on_aeoi, nested_mode;
  logic special_mask, read_isr, poll_mode, init_start, level_err;
  logic eoi_ns, eoi_sp, eoi_rotate, base_load;
  logic [7:0] rd_data, imr, vec_base;
  logic [2:0] eoi_level, base_val;

  always #(CYC/2) clk = ~clk;

  pic_cmd_decoder u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0, comparing = 0;

  // Behavioural reference model (st: 0 ready, 1 second, 2 third, 3 fourth word)
  int m_st, m_need4, m_single, m_vb, m_aeoi, m_nest, m_imr, m_rot, m_smask;
  int m_risr, m_poll, m_init, m_lvl, m_ens, m_esp, m_erot, m_elv, m_bl, m_bv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_need4 = 0; m_single = 0; m_vb = 0; m_aeoi = 0; m_nest = 0;
      m_imr = 0; m_rot = 0; m_smask = 0; m_risr = 0; m_poll = 0; m_init = 0;
      m_lvl = 0; m_ens = 0; m_esp = 0; m_erot = 0; m_elv = 0; m_bl = 0; m_bv = 0;
    end else begin
      int d, code;
      d = wr_data; code = d / 32;
      m_init = 0; m_lvl = 0; m_ens = 0; m_esp = 0; m_erot = 0; m_bl = 0;
      if (rd_en && !rd_a0) m_poll = 0;
      if (wr_valid && !wr_a0 && d[4]) begin
        m_st = 1; m_single = d[1]; m_need4 = d[0]; m_aeoi = 0; m_nest = 0;
        m_imr = 0; m_rot = 0; m_smask = 0; m_risr = 0; m_poll = 0;
        m_init = 1; m_lvl = d[3]; m_bl = 1; m_bv = 0;
      end else if (wr_valid && wr_a0 && m_st != 0) begin
        if (m_st == 1) begin
          m_vb = d - (d % 8);
          m_st = !m_single ? 2 : (m_need4 ? 3 : 0);
        end else if (m_st == 2) m_st = m_need4 ? 3 : 0;
        else begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
      end else if (wr_valid && wr_a0) m_imr = d;
      else if (wr_valid && d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_risr = d[0];
        if (d[6]) m_smask = d[5];
      end else if (wr_valid) begin
        if (code == 0) m_rot = 0;
        if (code == 4) m_rot = 1;
        if (code == 1 || code == 5) m_ens = 1;
        if (code == 5) m_erot = 1;
        if (code == 3 || code == 7) begin m_esp = 1; m_elv = d % 8; end
        if (code == 6 || code == 7) begin m_bl = 1; m_bv = (d + 1) % 8; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = rd_a0 ? m_imr : (m_risr ? int'(isr_in) : int'(irr_in));
    chk("R1 init_start", init_start, m_init);
    chk("R1 single_mode", single_mode, m_single);
    chk("R2 level_err", level_err, m_lvl);
    chk("R3 vec_base", vec_base, m_vb);
    chk("R4 init_busy", init_busy, m_st != 0);
    chk("R5 nested_mode", nested_mode, m_nest);
    chk("R5 auto_eoi", auto_eoi, m_aeoi);
    chk("R6 imr", imr, m_imr);
    chk("R7 special_mask", special_mask, m_smask);
    chk("R7 read_isr", read_isr, m_risr);
    chk("R7 poll_mode", poll_mode, m_poll);
    chk("R8 rot_on_aeoi", rot_on_aeoi, m_rot);
    chk("R9 eoi_ns", eoi_ns, m_ens);
    chk("R9 eoi_sp", eoi_sp, m_esp);
    chk("R9 eoi_rotate", eoi_rotate, m_erot);
    chk("R9 eoi_level", eoi_level, m_elv);
    chk("R10 base_load", base_load, m_bl);
    chk("R10 base_val", base_val, m_bv);
    chk("R11 rd_data", rd_data, exp_rd);
    chk("R12 wr_ready", wr_ready, 1);
  endtask

  initial forever begin
    @(posedge clk); #5;
    if (rst_n && comparing && !done) compare_all();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // All tasks are entered at a falling edge and return at one.
  task automatic wr(input logic a0, input logic [7:0] d);
    wr_valid = 1; wr_a0 = a0; wr_data = d;
    @(negedge clk);
    wr_valid = 0; wr_data = ~d;
  endtask

  task automatic rd(input logic a0);
    rd_en = 1; rd_a0 = a0;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    #(CYC * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    irr_in = 8'h5A; isr_in = 8'hC3; rd_a0 = 0;
    @(negedge clk);
    // R13: reset state
    chk("R13 imr", imr, 0);
    chk("R13 init_busy", init_busy, 0);
    chk("R13 strobes", {init_start, level_err, eoi_ns, eoi_sp, base_load}, 0);
    chk("R13 modes", {single_mode, auto_eoi, rot_on_aeoi, nested_mode,
                      special_mask, read_isr, poll_mode}, 0);
    chk("R13 rd_data", rd_data, 8'h5A);
    comparing = 1;
    // single, with fourth word
    wr(0, 8'h13); wr(1, 8'h4D); wr(1, 8'h12);
    wr(1, 8'hA5); rd(1);
    rd(0);
    // status command variants
    wr(0, 8'h0B); rd(0); wr(0, 8'h08); rd(0); wr(0, 8'h0A); rd(0);
    wr(0, 8'h68); wr(0, 8'h28); wr(0, 8'h48);
    wr(0, 8'h0C); repeat (2) @(negedge clk); rd(1); rd(0);
    // poll set and poll read in the same cycle: set wins
    rd_en = 1; rd_a0 = 0; wr(0, 8'h0C); rd_en = 0; rd(0);
    // all end/rotate codes
    wr(0, 8'h80); wr(0, 8'h00); wr(0, 8'h20); wr(0, 8'hA0);
    wr(0, 8'h63); wr(0, 8'hE7); wr(0, 8'hC2); wr(0, 8'h45);
    wr(0, 8'hE3); wr(0, 8'h84); wr(0, 8'h24);
    // cascade, no fourth word; third word ignored
    wr(0, 8'h10); wr(1, 8'h27); wr(1, 8'hFF); wr(1, 8'h0F);
    // cascade with fourth word
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h04); wr(1, 8'h01); wr(1, 8'h3C);
    // single without fourth word
    wr(0, 8'h12); wr(1, 8'h30); wr(1, 8'h77);
    // level mode request; restart during sequence
    wr(0, 8'h18); wr(0, 8'h11); wr(0, 8'h13); wr(1, 8'hF9); wr(1, 8'h10);
    // idle with data toggling
    repeat (4) begin wr_data = 8'hFF; @(negedge clk); end
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      wr_valid = $urandom_range(0, 1);
      wr_a0    = $urandom_range(0, 2) == 0;
      wr_data  = 8'($urandom);
      rd_en    = $urandom_range(0, 1);
      rd_a0    = $urandom_range(0, 1);
      irr_in   = 8'($urandom);
      isr_in   = 8'($urandom);
      @(negedge clk);
    end
    wr_valid = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule